// File: doc/BRIEF.md
# Serial DAC Frame Generator

This block sits in a host chip and drives an 8-bit serial DAC over a chip-select, frame-sync, clock and data link, all timed from the system clock. Software or a control engine hands it requests on a valid/ready port. A request is either a configuration change (speed, power-down and a 2-bit reference choice) or a new 8-bit output code. The block turns each request into a 16-bit word and shifts it out MSB first. The receiver samples data on falling serial-clock edges, so data only moves on rising edges.

Every interval on the link is a count of system-clock cycles: chip-select lead, frame-sync lead, serial-clock half period, end-of-frame tail, frame-sync high time and the pause between bytes. Out of reset, the block sends one configuration word built from its parameters before it accepts any request. Later configuration requests cause a frame only when they change the stored settings. Each frame can instead go out as two 8-bit halves with frame-sync held low between them, for hosts that move bytes.

Top module: `sdac_framer`

## Requirements
- R1: While reset is asserted, `cs_n`, `fs_n` and `sclk` are high and `req_ready` is low.
- R2: After reset the first frame is a configuration word made from INIT_FAST, INIT_PDOWN and INIT_REF. No request is accepted before that frame's frame-sync rises.
- R3: A configuration word is bit15=1, bit14=fast, bit13=power-down, bit12=1, bits 11..2 zero and bits 1..0 the reference select. Fast mode with reference 2'b10 gives 16'hD002.
- R4: A data word is bit15=0, bit14=fast, bit13=power-down, bit12=0, bits 11..4 the code and bits 3..0 zero. Speed and power-down come from the stored configuration.
- R5: A configuration request equal to the stored settings is accepted and sends no frame. A differing one is stored and sends exactly one configuration frame.
- R6: `req_ready` is high only when both `cs_n` and `fs_n` are high. It stays low from the start of a frame until its frame-sync high interval has elapsed.
- R7: `cs_n` falls at least CS_LEAD_CYC cycles before `fs_n` falls. `fs_n` falls at least FS_LEAD_CYC cycles before the first falling `sclk` edge.
- R8: Each frame has exactly 16 falling `sclk` edges, all while `fs_n` is low. Each high and low phase lasts at least HALF_CYC cycles, and bits go out MSB first.
- R9: `sdo` holds the same value in the cycle where `sclk` falls and throughout the low phase that follows.
- R10: `fs_n` and `cs_n` rise in the same cycle, at least END_CYC cycles after the 16th rising `sclk` edge. `fs_n` then stays high for at least FS_HIGH_CYC cycles.
- R11: With `byte_mode` high when a frame starts, the high phase after the 8th bit is stretched by BYTE_GAP_CYC cycles with `fs_n` still low. Without it, that phase lasts exactly HALF_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_ctrl | input | 1 | 1 = configuration request, 0 = data request |
| req_fast | input | 1 | Fast settling mode |
| req_pdown | input | 1 | Power-down |
| req_ref | input | 2 | Reference select |
| req_code | input | 8 | DAC code for a data request |
| byte_mode | input | 1 | Send the frame as two 8-bit halves |
| cs_n | output | 1 | Chip select, active low |
| fs_n | output | 1 | Frame sync, active low |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data |

## Verification
The assertions assume the request fields and `byte_mode` stay steady while `req_valid` is high. They also assume each interval parameter is at least one cycle. The stimulus meets both conditions: it changes inputs only on falling system-clock edges, holds them until the handshake completes, and keeps `byte_mode` for one more cycle so that a configuration frame, which starts the cycle after acceptance, sees the value sent with its request. Random codes, random configuration changes (some repeating the stored settings) and random byte-mode choices are mixed with all-zero and all-one codes and a request held during reset.

// File: rtl/sdac_framer.sv
module sdac_framer #(
  parameter int HALF_CYC     = 2,
  parameter int CS_LEAD_CYC  = 1,
  parameter int FS_LEAD_CYC  = 1,
  parameter int END_CYC      = 1,
  parameter int FS_HIGH_CYC  = 2,
  parameter int BYTE_GAP_CYC = 3,
  parameter bit INIT_FAST    = 1'b1,
  parameter bit INIT_PDOWN   = 1'b0,
  parameter logic [1:0] INIT_REF = 2'b10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_ctrl,
  input  logic       req_fast,
  input  logic       req_pdown,
  input  logic [1:0] req_ref,
  input  logic [7:0] req_code,
  input  logic       byte_mode,
  output logic       cs_n,
  output logic       fs_n,
  output logic       sclk,
  output logic       sdo
);
  localparam int WORD_W = 16;
  localparam int HALF_W = WORD_W / 2;
  localparam int BIT_W  = $clog2(WORD_W + 1);

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXC = imax(imax(imax(HALF_CYC, CS_LEAD_CYC), imax(FS_LEAD_CYC, END_CYC)),
                             imax(FS_HIGH_CYC, BYTE_GAP_CYC));
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_CSLEAD, S_FSLEAD, S_LOW, S_HIGH, S_GAP, S_TAIL, S_FSHI} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [BIT_W-1:0] nfall;
  logic [WORD_W-1:0] word;
  logic             byte_q, need_ctrl, c_fast, c_pdown;
  logic [1:0]       c_ref;

  wire tick       = (cnt == '0);
  wire take       = req_valid && req_ready;
  wire cfg_diff   = {req_fast, req_pdown, req_ref} != {c_fast, c_pdown, c_ref};
  wire start_ctrl = (st == S_IDLE) && need_ctrl;
  wire start_data = take && !req_ctrl;

  assign req_ready = (st == S_IDLE) && !need_ctrl;
  assign sdo = word[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; nfall <= '0; word <= '0; byte_q <= 1'b0;
      cs_n <= 1'b1; fs_n <= 1'b1; sclk <= 1'b1;
      c_fast <= INIT_FAST; c_pdown <= INIT_PDOWN; c_ref <= INIT_REF;
      need_ctrl <= 1'b1;
    end else begin
      if (take && req_ctrl && cfg_diff) begin
        c_fast <= req_fast; c_pdown <= req_pdown; c_ref <= req_ref;
        need_ctrl <= 1'b1;
      end
      if (st != S_IDLE && !tick) cnt <= cnt - 1'b1;
      case (st)
        S_IDLE: if (start_ctrl || start_data) begin
          st <= S_CSLEAD; cs_n <= 1'b0; cnt <= CW'(CS_LEAD_CYC - 1);
          nfall <= '0; byte_q <= byte_mode;
          word <= start_ctrl ? {1'b1, c_fast, c_pdown, 1'b1, 10'd0, c_ref}
                             : {1'b0, c_fast, c_pdown, 1'b0, req_code, 4'd0};
          if (start_ctrl) need_ctrl <= 1'b0;
        end
        S_CSLEAD: if (tick) begin
          fs_n <= 1'b0; st <= S_FSLEAD; cnt <= CW'(FS_LEAD_CYC - 1);
        end
        S_FSLEAD, S_HIGH: if (tick) begin
          sclk <= 1'b0; nfall <= nfall + 1'b1; st <= S_LOW; cnt <= CW'(HALF_CYC - 1);
        end
        S_GAP: if (tick) begin
          st <= S_HIGH; cnt <= CW'(HALF_CYC - 1);
        end
        S_LOW: if (tick) begin
          sclk <= 1'b1;
          if (nfall == BIT_W'(WORD_W)) begin
            st <= S_TAIL; cnt <= CW'(END_CYC - 1);
          end else begin
            word <= {word[WORD_W-2:0], 1'b0};
            if (byte_q && nfall == BIT_W'(HALF_W)) begin
              st <= S_GAP; cnt <= CW'(BYTE_GAP_CYC - 1);
            end else begin
              st <= S_HIGH; cnt <= CW'(HALF_CYC - 1);
            end
          end
        end
        S_TAIL: if (tick) begin
          fs_n <= 1'b1; cs_n <= 1'b1; st <= S_FSHI; cnt <= CW'(FS_HIGH_CYC - 1);
        end
        S_FSHI: if (tick) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_ready_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && fs_n));
  assert_fs_inside_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fs_n) |-> (!cs_n && $past(!cs_n)));
  assert_sclk_framed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> !fs_n);
  assert_sdo_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> $stable(sdo));
  assert_end_together_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_n) |-> $rose(cs_n));
  assert_ctrl_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_ctrl && !cfg_diff) |=> !need_ctrl);
endmodule

// File: tb/sdac_framer_bench.sv
module sdac_framer_bench;
  localparam int HALF = 2, CSL = 1, FSL = 1, ENDC = 1, FSH = 2, GAP = 3;
  localparam bit I_FAST = 1'b1, I_PD = 1'b0;
  localparam logic [1:0] I_REF = 2'b10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ctrl = 0, req_fast = 0, req_pdown = 0, byte_mode = 0;
  logic [1:0] req_ref = 0;
  logic [7:0] req_code = 0;
  logic req_ready, cs_n, fs_n, sclk, sdo;

  always #10 clk = ~clk;

  sdac_framer #(.HALF_CYC(HALF), .CS_LEAD_CYC(CSL), .FS_LEAD_CYC(FSL), .END_CYC(ENDC),
    .FS_HIGH_CYC(FSH), .BYTE_GAP_CYC(GAP), .INIT_FAST(I_FAST), .INIT_PDOWN(I_PD),
    .INIT_REF(I_REF)) u_sdac_framer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ctrl(req_ctrl), .req_fast(req_fast), .req_pdown(req_pdown), .req_ref(req_ref),
    .req_code(req_code), .byte_mode(byte_mode), .cs_n(cs_n), .fs_n(fs_n),
    .sclk(sclk), .sdo(sdo));

  int total = 0, bad = 0, wr = 0, rd = 0, ncs = 0;
  bit finished = 0;
  logic [15:0] exp_word [0:255];
  bit exp_byte [0:255];
  bit exp_ctl [0:255];
  logic m_fast = I_FAST, m_pd = I_PD;
  logic [1:0] m_ref = I_REF;

  function automatic logic [15:0] ctl_word(input logic f, input logic p, input logic [1:0] r);
    return {1'b1, f, p, 1'b1, 10'd0, r};
  endfunction
  function automatic logic [15:0] dat_word(input logic f, input logic p, input logic [7:0] c);
    return {1'b0, f, p, 1'b0, c, 4'd0};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor
  logic p_cs = 1, p_fs = 1, p_sclk = 1, p_sdo = 0;
  int t_cs = 0, t_fs = 0, t_run = 0, t_r16 = 0, t_fsh = 1000, nfall = 0, run8 = 0;
  logic [15:0] bits = 0;

  always @(negedge clk) if (rst_n) begin
    t_cs++; t_fs++; t_run++; t_r16++; t_fsh++;
    if (req_ready && !(cs_n && fs_n)) chk(0, "R6 ready during frame", req_ready, 0);
    if (req_valid && req_ready && rd == 0) chk(0, "R2 request taken before first frame", rd, 1);
    if (p_cs && !cs_n) begin t_cs = 0; ncs++; end
    if (p_fs && !fs_n) begin
      chk(t_cs >= CSL, "R7 cs lead", t_cs, CSL);
      chk(t_fsh >= FSH, "R10 fs high time", t_fsh, FSH);
      nfall = 0; t_fs = 0; bits = 0;
    end
    if (p_sclk && !sclk) begin
      if (nfall == 0) chk(t_fs >= FSL, "R7 fs lead", t_fs, FSL);
      else chk(t_run >= HALF, "R8 high phase", t_run, HALF);
      if (nfall == 8) run8 = t_run;
      chk(sdo == p_sdo, "R9 setup", sdo, p_sdo);
      chk(!fs_n, "R8 edge outside frame", fs_n, 0);
      bits = {bits[14:0], sdo};
      nfall++; t_run = 0;
    end else if (!p_sclk && sclk) begin
      chk(t_run >= HALF, "R8 low phase", t_run, HALF);
      if (nfall == 16) t_r16 = 0;
      t_run = 0;
    end else if (!p_sclk && !sclk) begin
      if (sdo != p_sdo) chk(0, "R9 hold", sdo, p_sdo);
    end
    if (!p_fs && fs_n) begin
      chk(!p_cs && cs_n, "R10 cs with fs", cs_n, 1);
      chk(t_r16 >= ENDC, "R10 tail", t_r16, ENDC);
      chk(nfall == 16, "R8 edge count", nfall, 16);
      if (rd >= wr) chk(0, "R5 unexpected frame", bits, 0);
      else begin
        if (exp_ctl[rd]) chk(bits == exp_word[rd], "R3 control word", bits, exp_word[rd]);
        else chk(bits == exp_word[rd], "R4 data word", bits, exp_word[rd]);
        if (exp_byte[rd]) chk(run8 == HALF + GAP, "R11 byte pause", run8, HALF + GAP);
        else chk(run8 == HALF, "R11 no pause", run8, HALF);
        rd++;
      end
      t_fsh = 0;
    end
    p_cs = cs_n; p_fs = fs_n; p_sclk = sclk; p_sdo = sdo;
  end

  task automatic handshake();
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0;
    @(negedge clk);
  endtask

  task automatic push_data(input logic [7:0] code, input bit bm);
    @(negedge clk);
    req_valid = 1; req_ctrl = 0; req_code = code; byte_mode = bm;
    exp_word[wr] = dat_word(m_fast, m_pd, code); exp_byte[wr] = bm; exp_ctl[wr] = 0; wr++;
    handshake();
  endtask

  task automatic push_ctrl(input logic f, input logic p, input logic [1:0] r, input bit bm);
    @(negedge clk);
    req_valid = 1; req_ctrl = 1; req_fast = f; req_pdown = p; req_ref = r; byte_mode = bm;
    if ({f, p, r} != {m_fast, m_pd, m_ref}) begin
      m_fast = f; m_pd = p; m_ref = r;
      exp_word[wr] = ctl_word(f, p, r); exp_byte[wr] = bm; exp_ctl[wr] = 1; wr++;
    end
    handshake();
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && (rd != wr || !cs_n); i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int seen;
    void'($urandom(32'h1357));
    // R2: data request already waiting during reset
    req_valid = 1; req_ctrl = 0; req_code = 8'h5A; byte_mode = 0;
    exp_word[0] = ctl_word(I_FAST, I_PD, I_REF); exp_byte[0] = 0; exp_ctl[0] = 1;
    exp_word[1] = dat_word(I_FAST, I_PD, 8'h5A); exp_byte[1] = 0; exp_ctl[1] = 0;
    wr = 2;
    repeat (3) @(negedge clk);
    chk(cs_n && fs_n && sclk, "R1 idle levels in reset", {cs_n, fs_n, sclk}, 3'b111);
    chk(!req_ready, "R1 ready low in reset", req_ready, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!req_ready, "R2 ready low before startup frame", req_ready, 0);
    handshake();
    drain();
    chk(exp_word[0] == 16'hD002, "R3 startup word value", exp_word[0], 16'hD002);
    push_data(8'h00, 0);
    push_data(8'hFF, 0);
    push_data(8'h3C, 1);
    drain();
    push_ctrl(1'b0, 1'b1, 2'b01, 0);
    push_data(8'hA5, 0);
    push_ctrl(1'b1, 1'b0, 2'b11, 1);
    push_data(8'h81, 1);
    drain();
    for (int i = 0; i < 40; i++) begin
      int r = $urandom % 6;
      bit bm = $urandom % 2;
      if (r == 0) push_ctrl($urandom % 2, $urandom % 2, 2'($urandom % 4), bm);
      else if (r == 1) push_ctrl(m_fast, m_pd, m_ref, bm);
      else push_data(8'($urandom), bm);
    end
    drain();
    // R5: repeated configuration produces no frame
    seen = ncs;
    push_ctrl(m_fast, m_pd, m_ref, 0);
    repeat (80) @(negedge clk);
    chk(ncs == seen, "R5 repeat config sent a frame", ncs, seen);
    push_data(8'h42, 0);
    drain();
    chk(rd == wr, "R5 frame count", rd, wr);
    finish_run();
  end
endmodule